// File: doc/BRIEF.md
# Peak-Index Switching Timing Selector

This block sits behind a pair of correlation peak qualifiers in a full-duplex OFDM receiver. Each qualifier reports, once per synchronization symbol, the lag at which its correlation peaked and whether that peak was strong enough to trust. One reference is the partner node's sequence, which locates the desired signal. The other is the node's own transmitted sequence, which locates the self-interference. Both sequences are carried in the final symbol of the opening slot of every half frame.

When a result strobe arrives, the block decides which detected lag each of its two timing registers adopts. A qualified reference updates its own register. If only one reference qualifies, its lag is copied into both registers, because the two arrivals are held within one cyclic prefix of each other. If neither qualifies, the stored timings are kept and a new correlation attempt is requested. A lock flag shows that at least one accepted update has happened since reset. A two-bit code reports which of the four cases the latest decision fell into.

Top module: `psw_top`

## Requirements
- R1: On a result strobe where both pass flags are high, at the next clock edge `des_timing` takes `des_idx` and `si_timing` takes `si_idx`.
- R2: On a result strobe where only `des_pass` is high, at the next clock edge both `des_timing` and `si_timing` take `des_idx`.
- R3: On a result strobe where only `si_pass` is high, at the next clock edge both `des_timing` and `si_timing` take `si_idx`.
- R4: On a result strobe where both pass flags are low, both timing registers keep their values.
- R5: `retry` is high for exactly the one cycle after a strobe whose pass flags are both low, and low in every other cycle. Back-to-back failing strobes give back-to-back retry cycles.
- R6: `locked` is low after reset. It rises at the clock edge of the first strobe that has at least one pass flag high, and then stays high through later failing strobes until the next reset.
- R7: `case_code` is updated at the clock edge of each strobe and held between strobes. Bit 0 is the desired pass flag and bit 1 is the self-interference pass flag: 2'b11 both, 2'b01 desired only, 2'b10 self only, 2'b00 none.
- R8: While `rst_n` is low and after its release, `des_timing`, `si_timing`, `case_code`, `locked` and `retry` are all zero.
- R9: In cycles without `res_valid`, the indices and pass flags have no effect on any output.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Qualifier result strobe, one cycle per evaluation |
| des_idx | input | IDX_W | Peak lag found against the partner's sequence |
| des_pass | input | 1 | Partner-sequence peak exceeded the threshold |
| si_idx | input | IDX_W | Peak lag found against the node's own sequence |
| si_pass | input | 1 | Own-sequence peak exceeded the threshold |
| des_timing | output | IDX_W | Stored timing for the desired signal |
| si_timing | output | IDX_W | Stored timing for the self-interference |
| locked | output | 1 | At least one accepted update since reset |
| retry | output | 1 | One-cycle request for a new correlation attempt |
| case_code | output | 2 | Case of the latest decision |

## Verification
The bench builds the block with the default 12-bit index width. At this width the full lag range fits in a short run, so the stimulus can place the extreme lags 0 and 4095 and many random lags into every decision case. The stimulus also covers failing strobes that come back to back, failing strobes before the first lock, idle cycles with changing inputs, and a reset taken in the middle of the run.

// File: rtl/psw_pkg.sv
package psw_pkg;

    // bit 0: desired reference passed, bit 1: self-interference reference passed
    typedef enum logic [1:0] {
        PICK_NONE = 2'b00,
        PICK_DES  = 2'b01,
        PICK_SELF = 2'b10,
        PICK_BOTH = 2'b11
    } pick_e;

endpackage

// File: rtl/psw_classify.sv
module psw_classify
    import psw_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0] des_idx,
    input  logic             des_pass,
    input  logic [IDX_W-1:0] si_idx,
    input  logic             si_pass,
    output pick_e            pick,
    output logic [IDX_W-1:0] des_sel,
    output logic [IDX_W-1:0] si_sel,
    output logic             accept
);

    always_comb begin
        pick    = pick_e'({si_pass, des_pass});
        des_sel = des_idx;
        si_sel  = si_idx;
        accept  = 1'b1;
        unique case (pick)
            PICK_BOTH: begin
                des_sel = des_idx;
                si_sel  = si_idx;
            end
            PICK_DES: begin
                des_sel = des_idx;
                si_sel  = des_idx;
            end
            PICK_SELF: begin
                des_sel = si_idx;
                si_sel  = si_idx;
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/psw_timing_reg.sv
module psw_timing_reg #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic             accept,
    input  logic             des_pass,
    input  logic             si_pass,
    input  logic [IDX_W-1:0] des_sel,
    input  logic [IDX_W-1:0] si_sel,
    output logic [IDX_W-1:0] des_timing,
    output logic [IDX_W-1:0] si_timing
);

    typedef struct packed {
        logic [IDX_W-1:0] des;
        logic [IDX_W-1:0] si;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        tim_d = tim_q;
        if (res_valid && accept) begin
            tim_d.des = des_sel;
            tim_d.si  = si_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign des_timing = tim_q.des;
    assign si_timing  = tim_q.si;

    // R4: a strobe where both flags fail leaves the stored timings untouched
    assert_hold_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !des_pass && !si_pass) |=> ($stable(des_timing) && $stable(si_timing)));

    // R9: without a strobe the timings never move
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(des_timing) && $stable(si_timing)));

endmodule

// File: rtl/psw_status.sv
module psw_status
    import psw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       res_valid,
    input  logic       des_pass,
    input  logic       si_pass,
    input  pick_e      pick,
    input  logic       accept,
    output logic       locked,
    output logic       retry,
    output logic [1:0] case_code
);

    typedef struct packed {
        logic  locked;
        logic  retry;
        pick_e code;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.retry = 1'b0;
        if (res_valid) begin
            st_d.code = pick;
            if (accept) st_d.locked = 1'b1;
            else        st_d.retry  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{locked: 1'b0, retry: 1'b0, code: PICK_NONE};
        else        st_q <= st_d;
    end

    assign locked    = st_q.locked;
    assign retry     = st_q.retry;
    assign case_code = st_q.code;

    // R5: a retry cycle is always preceded by a failing strobe
    assert_retry_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> $past(res_valid && !des_pass && !si_pass));

    // R5: a failing strobe always yields a retry cycle
    assert_retry_issued_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !des_pass && !si_pass) |=> retry);

    // R6: once locked, the flag stays up until reset
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R7: the code follows the flags of each strobe
    assert_code_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (case_code == $past({si_pass, des_pass})));

endmodule

// File: rtl/psw_top.sv
module psw_top
    import psw_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [IDX_W-1:0] des_idx,
    input  logic             des_pass,
    input  logic [IDX_W-1:0] si_idx,
    input  logic             si_pass,
    output logic [IDX_W-1:0] des_timing,
    output logic [IDX_W-1:0] si_timing,
    output logic             locked,
    output logic             retry,
    output logic [1:0]       case_code
);

    pick_e            pick;
    logic [IDX_W-1:0] des_sel;
    logic [IDX_W-1:0] si_sel;
    logic             accept;

    psw_classify #(.IDX_W(IDX_W)) u_classify (
        .des_idx  (des_idx),
        .des_pass (des_pass),
        .si_idx   (si_idx),
        .si_pass  (si_pass),
        .pick     (pick),
        .des_sel  (des_sel),
        .si_sel   (si_sel),
        .accept   (accept)
    );

    psw_timing_reg #(.IDX_W(IDX_W)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .accept     (accept),
        .des_pass   (des_pass),
        .si_pass    (si_pass),
        .des_sel    (des_sel),
        .si_sel     (si_sel),
        .des_timing (des_timing),
        .si_timing  (si_timing)
    );

    psw_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .des_pass  (des_pass),
        .si_pass   (si_pass),
        .pick      (pick),
        .accept    (accept),
        .locked    (locked),
        .retry     (retry),
        .case_code (case_code)
    );

    // R1: both references qualify, each timing follows its own index
    assert_both_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && des_pass && si_pass) |=>
            (des_timing == $past(des_idx) && si_timing == $past(si_idx)));

    // R2: only the desired reference qualifies, its index goes to both
    assert_des_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && des_pass && !si_pass) |=>
            (des_timing == $past(des_idx) && si_timing == $past(des_idx)));

    // R3: only the self-interference reference qualifies, its index goes to both
    assert_si_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !des_pass && si_pass) |=>
            (des_timing == $past(si_idx) && si_timing == $past(si_idx)));

    // R6: an accepted strobe always leaves the block locked
    assert_lock_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (des_pass || si_pass)) |=> locked);

endmodule

// File: tb/psw_top_tb.sv
module psw_top_tb;

    localparam int  IDX_W  = 12;
    localparam time CLK_PD = 10ns;
    localparam int  MAXIDX = (1 << IDX_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             res_valid = 1'b0;
    logic [IDX_W-1:0] des_idx = '0;
    logic             des_pass = 1'b0;
    logic [IDX_W-1:0] si_idx = '0;
    logic             si_pass = 1'b0;
    logic [IDX_W-1:0] des_timing;
    logic [IDX_W-1:0] si_timing;
    logic             locked;
    logic             retry;
    logic [1:0]       case_code;

    psw_top #(.IDX_W(IDX_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .des_idx    (des_idx),
        .des_pass   (des_pass),
        .si_idx     (si_idx),
        .si_pass    (si_pass),
        .des_timing (des_timing),
        .si_timing  (si_timing),
        .locked     (locked),
        .retry      (retry),
        .case_code  (case_code)
    );

    always #(CLK_PD / 2) clk = ~clk;

    int n_vec  = 0;
    int n_miss = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural reference model
    int    m_des = 0, m_si = 0, m_code = 0;
    bit    m_lock = 0, m_retry = 0;
    string m_tag = "R8";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_des = 0; m_si = 0; m_code = 0; m_lock = 0; m_retry = 0; m_tag = "R8";
        end else begin
            m_retry = 0;
            if (!res_valid) begin
                m_tag = "R9";
            end else begin
                m_code = (si_pass ? 2 : 0) + (des_pass ? 1 : 0);
                if (des_pass && si_pass) begin
                    m_des = des_idx; m_si = si_idx; m_tag = "R1"; m_lock = 1;
                end else if (des_pass) begin
                    m_des = des_idx; m_si = des_idx; m_tag = "R2"; m_lock = 1;
                end else if (si_pass) begin
                    m_des = si_idx; m_si = si_idx; m_tag = "R3"; m_lock = 1;
                end else begin
                    m_retry = 1; m_tag = "R4";
                end
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            check(m_tag, "des_timing", int'(des_timing), m_des);
            check(m_tag, "si_timing", int'(si_timing), m_si);
            check(rst_n ? "R6" : "R8", "locked", int'(locked), int'(m_lock));
            check(rst_n ? "R5" : "R8", "retry", int'(retry), int'(m_retry));
            check(rst_n ? "R7" : "R8", "case_code", int'(case_code), m_code);
        end
    end

    task automatic strobe(input bit dp, input int di, input bit sp, input int sidx);
        @(negedge clk);
        res_valid = 1'b1;
        des_pass  = dp;
        des_idx   = IDX_W'(di);
        si_pass   = sp;
        si_idx    = IDX_W'(sidx);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic idle_noise(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            res_valid = 1'b0;
            des_pass  = $urandom_range(0, 1) == 1;
            si_pass   = $urandom_range(0, 1) == 1;
            des_idx   = IDX_W'($urandom_range(0, MAXIDX));
            si_idx    = IDX_W'($urandom_range(0, MAXIDX));
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_miss++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            finish_run();
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: idle noise before any strobe
        idle_noise(5);
        // R4/R5: failing strobe before lock, R6 stays low
        strobe(0, 100, 0, 200);
        idle_noise(2);
        // R1
        strobe(1, 17, 1, 33);
        // R2 with the top lag
        strobe(1, MAXIDX, 0, 5);
        // R3 with lag zero
        strobe(0, 4000, 1, 0);
        // R4/R5/R6: back-to-back failing strobes after lock
        strobe(0, 1, 0, 2);
        @(negedge clk);
        res_valid = 1'b1; des_pass = 0; si_pass = 0;
        @(negedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        idle_noise(4);
        // R1 at extremes
        strobe(1, 0, 1, MAXIDX);
        // random traffic including consecutive strobes
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            res_valid = $urandom_range(0, 2) != 0;
            des_pass  = $urandom_range(0, 1) == 1;
            si_pass   = $urandom_range(0, 1) == 1;
            des_idx   = IDX_W'($urandom_range(0, MAXIDX));
            si_idx    = IDX_W'($urandom_range(0, MAXIDX));
        end
        // R8: reset in mid-run, then relock
        @(negedge clk);
        res_valid = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        res_valid = 1'b0;
        rst_n = 1'b1;
        idle_noise(3);
        strobe(0, 9, 0, 9);
        strobe(0, 7, 1, 1234);
        idle_noise(3);
        @(negedge clk);
        finish_run();
    end

endmodule